// File: doc/BRIEF.md
# LCD Frame Setup and Palette Engine

This engine prepares one display frame each time the panel timing asks for it. On a frame-start pulse it first checks that the frame-buffer windows lie inside an allowed address range. Depending on the load mode, it then fetches a 256-entry halfword palette from the start of the current buffer through a valid/ready read port. It decodes the pixel depth from the header field of palette entry 0 and computes where pixel data begins. It checks that the whole frame fits the buffer. When the frame is accepted it publishes the pixel base address, bits per pixel, colour format, line stride, first line and line count.

The engine keeps its own active state. It becomes active on a rising edge of the enable input and drops out on its own when it finds a fault. To clear a fault, the enable input must be taken low and then high again. With two buffers, the engine alternates between them on every accepted frame. Condition pulses and a DMA interrupt pulse report each outcome. The palette remains readable through a separate 256x16 read port.

The read request obeys normal back-pressure rules. Once `rd_req_valid` is high, the request address stays unchanged until the cycle in which `rd_req_ready` is high. Only one request is outstanding at a time. The memory answers each accepted request with a single `rd_rsp_valid` beat some cycles later. The engine always takes a response and never stalls it. Configuration inputs are expected to stay stable while a setup is in progress.

Top module: `lcd_frame_setup`

## Requirements
- R1: After reset, `active`, `rd_req_valid`, all event pulses, `pix_base`, `bpp` and `line_count` are 0.
- R2: A frame start has no effect (no read request, no event) while `active` is 0 or while `load_mode` equals 1; a rising edge of `ctl_en` sets `active`.
- R3: If buffer 0 top or bottom lies outside [`valid_lo`,`valid_hi`], or `dual_en` is 1 and buffer 1 top or bottom does too, the engine pulses `cond_evt[2]`, pulses `dma_irq` when `dma_ie[1]` is 1, and clears `active` the next cycle; buffer 1 is ignored when `dual_en` is 0.
- R4: Unless `load_mode` equals 2, exactly 256 halfword reads are made at current-buffer top plus 2*i, word i lands in palette entry i, readable at `pal_rd_data` one cycle after `pal_rd_idx`, and `pal_loaded` pulses once; with `load_mode` 2 no reads are made and the old palette is kept.
- R5: While `rd_req_valid` is 1 and `rd_req_ready` is 0, the request stays valid with an unchanged address.
- R6: The depth code is palette entry 0 bits 14:12: code 1 gives `bpp`=2, 2 gives 4, 3 gives 8, 4 to 7 give 16; code 0 pulses `depth_skip` and nothing else.
- R7: `fmt12` is 1 exactly when an accepted frame is 16 bpp and `tft_en` is 0.
- R8: The data offset is 0x200 for codes 3 to 7, 0x20 for codes 1 and 2, and 0 with `load_mode` 2; `pix_base` is current top plus that offset.
- R9: With size = bottom - top of the current buffer, when offset + width*height*bpp/8 exceeds size + 2 the engine pulses `sync_err` and clears `active`; equal to size + 2 is accepted.
- R10: On acceptance `setup_done` pulses, `cond_evt` bit 0 (buffer 0) or bit 1 (buffer 1) pulses, `dma_irq` pulses exactly when `dma_ie[0]` is 1, and `line_stride` equals width*bpp/8 (integer).
- R11: With `dual_en` 1 the buffer index toggles after each accepted frame; with `dual_en` 0 it stays; after re-enable the first frame uses buffer 0.
- R12: If `subpanel[31]` is 1 and `subpanel[29]` is 1, `first_line` is `subpanel[25:16]` and `line_count` is the height; if `subpanel[29]` is 0, `first_line` is 0 and `line_count` is `subpanel[25:16]`; with bit 31 clear, first line 0 and the full height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_en | input | 1 | Controller enable level; rising edge activates |
| frame_start | input | 1 | One-cycle request to set up a frame |
| load_mode | input | 2 | 1: no setup, 2: data only, 0/3: palette and data |
| tft_en | input | 1 | Active-matrix panel selects 16-bit colour at 16 bpp |
| width_m1 | input | 10 | Width minus one |
| height_m1 | input | 10 | Height minus one |
| subpanel | input | 32 | Subpanel control word |
| buf0_top | input | 32 | Buffer 0 start address |
| buf0_bot | input | 32 | Buffer 0 end address |
| buf1_top | input | 32 | Buffer 1 start address |
| buf1_bot | input | 32 | Buffer 1 end address |
| dual_en | input | 1 | Alternate between two buffers |
| dma_ie | input | 2 | Bit 0: interrupt on accept; bit 1: on window fault |
| valid_lo | input | 32 | Lowest legal address |
| valid_hi | input | 32 | Highest legal address |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | 32 | Read byte address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 16 | Read halfword |
| pal_rd_idx | input | 8 | Palette read index |
| pal_rd_data | output | 16 | Palette entry, one cycle later |
| active | output | 1 | Engine enabled and fault-free |
| cur_buf | output | 1 | Current buffer index |
| pix_base | output | 32 | First pixel address |
| bpp | output | 5 | Bits per pixel |
| fmt12 | output | 1 | 12-bit colour format at 16 bpp |
| line_stride | output | 12 | Bytes per line |
| first_line | output | 10 | First displayed line |
| line_count | output | 11 | Displayed line count |
| setup_done | output | 1 | Frame accepted pulse |
| pal_loaded | output | 1 | Palette load finished pulse |
| depth_skip | output | 1 | Unsupported depth pulse |
| sync_err | output | 1 | Frame overrun pulse |
| cond_evt | output | 3 | Condition pulses: buf0, buf1, window fault |
| dma_irq | output | 1 | DMA interrupt pulse |

## Verification
The hardest case to reach is a frame whose size sits exactly at the two-byte slack, on either side of it. The test table therefore sets the buffer bottom so that the required bytes equal size + 2 in one row and size + 3 in the next. A second hard case is a depth taken from a stale palette. It is reached by following a palette-loading row with a data-only row whose memory header carries a different code. The read port is stalled by a pseudo-random ready pattern through every palette fetch. The dual-buffer and re-enable ordering come from directed sequences that toggle `ctl_en` between frames.

// File: rtl/lcd_fs_pkg.sv
package lcd_fs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_ISSUE,
    ST_WAIT,
    ST_EVAL
  } fs_state_t;

  localparam logic [1:0] MODE_NO_SETUP = 2'd1;
  localparam logic [1:0] MODE_DATA_ONLY = 2'd2;

  localparam int DEPTH_LSB = 12;

  // log2 of bits per pixel for a depth code (code 0 handled by caller)
  function automatic logic [2:0] depth_log2(input logic [2:0] code);
    case (code)
      3'd1:    depth_log2 = 3'd1;
      3'd2:    depth_log2 = 3'd2;
      3'd3:    depth_log2 = 3'd3;
      default: depth_log2 = 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/lcd_fs_win.sv
module lcd_fs_win #(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [AW-1:0] lo,
  input  logic [AW-1:0] hi,
  output logic          ok
);
  assign ok = (addr >= lo) && (addr <= hi);
endmodule

// File: rtl/lcd_fs_pal.sv
module lcd_fs_pal #(
  parameter int DW    = 16,
  parameter int PAL_N = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [$clog2(PAL_N)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic [$clog2(PAL_N)-1:0] raddr,
  output logic [DW-1:0]            rdata,
  output logic [DW-1:0]            word0
);
  logic [DW-1:0] mem [PAL_N];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < PAL_N; i++) mem[i] <= '0;
      rdata <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
    end
  end

  assign word0 = mem[0];
endmodule

// File: rtl/lcd_fs_geom.sv
module lcd_fs_geom
  import lcd_fs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 10,
  parameter int DW    = 16
) (
  input  logic [DW-1:0]    hdr,
  input  logic             tft,
  input  logic [1:0]       lmode,
  input  logic [DIM_W-1:0] width_m1,
  input  logic [DIM_W-1:0] height_m1,
  input  logic [31:0]      subpanel,
  input  logic [AW-1:0]    top,
  input  logic [AW-1:0]    bot,
  output logic             code_zero,
  output logic [4:0]       bpp,
  output logic             fmt12,
  output logic [AW-1:0]    offset,
  output logic [DIM_W+1:0] stride,
  output logic             overrun,
  output logic [DIM_W-1:0] first,
  output logic [DIM_W:0]   lines
);
  localparam int PW = 2 * (DIM_W + 1);
  localparam int NW = AW + 2;
  localparam int SW = DIM_W + 6;

  logic [2:0]       code;
  logic [2:0]       lg;
  logic [DIM_W:0]   w, h;
  logic [PW-1:0]    pix;
  logic [NW-1:0]    bytes, need, room;
  logic [SW-1:0]    sbytes;
  logic [DIM_W-1:0] fld;

  assign code      = hdr[DEPTH_LSB+2:DEPTH_LSB];
  assign code_zero = (code == 3'd0);
  assign lg        = depth_log2(code);
  assign bpp       = 5'd1 << lg;
  assign fmt12     = (lg == 3'd4) && !tft;

  always_comb begin
    if (lmode == MODE_DATA_ONLY) offset = '0;
    else if (code >= 3'd3)       offset = AW'(12'h200);
    else                         offset = AW'(8'h20);
  end

  assign w      = {1'b0, width_m1} + (DIM_W+1)'(1);
  assign h      = {1'b0, height_m1} + (DIM_W+1)'(1);
  assign pix    = PW'(w) * PW'(h);
  assign bytes  = (NW'(pix) << lg) >> 3;
  assign need   = NW'(offset) + bytes;
  assign room   = NW'(bot) - NW'(top) + NW'(2);
  assign overrun = $signed(need) > $signed(room);

  assign sbytes = (SW'(w) << lg) >> 3;
  assign stride = sbytes[DIM_W+1:0];

  assign fld = subpanel[16+DIM_W-1:16];
  always_comb begin
    first = '0;
    lines = h;
    if (subpanel[31]) begin
      if (subpanel[29]) first = fld;
      else              lines = {1'b0, fld};
    end
  end
endmodule

// File: rtl/lcd_frame_setup.sv
module lcd_frame_setup
  import lcd_fs_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DIM_W = 10,
  parameter int DW    = 16,
  parameter int PAL_N = 256
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ctl_en,
  input  logic                     frame_start,
  input  logic [1:0]               load_mode,
  input  logic                     tft_en,
  input  logic [DIM_W-1:0]         width_m1,
  input  logic [DIM_W-1:0]         height_m1,
  input  logic [31:0]              subpanel,
  input  logic [AW-1:0]            buf0_top,
  input  logic [AW-1:0]            buf0_bot,
  input  logic [AW-1:0]            buf1_top,
  input  logic [AW-1:0]            buf1_bot,
  input  logic                     dual_en,
  input  logic [1:0]               dma_ie,
  input  logic [AW-1:0]            valid_lo,
  input  logic [AW-1:0]            valid_hi,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [AW-1:0]            rd_req_addr,
  input  logic                     rd_rsp_valid,
  input  logic [DW-1:0]            rd_rsp_data,
  input  logic [$clog2(PAL_N)-1:0] pal_rd_idx,
  output logic [DW-1:0]            pal_rd_data,
  output logic                     active,
  output logic                     cur_buf,
  output logic [AW-1:0]            pix_base,
  output logic [4:0]               bpp,
  output logic                     fmt12,
  output logic [DIM_W+1:0]         line_stride,
  output logic [DIM_W-1:0]         first_line,
  output logic [DIM_W:0]           line_count,
  output logic                     setup_done,
  output logic                     pal_loaded,
  output logic                     depth_skip,
  output logic                     sync_err,
  output logic [2:0]               cond_evt,
  output logic                     dma_irq
);
  localparam int PAL_AW = $clog2(PAL_N);
  localparam int NCHK   = 4;

  fs_state_t         st;
  logic [PAL_AW-1:0] cnt;
  logic              idx, en_q, fresh, shut;
  logic [AW-1:0]     top_cur, bot_cur;
  logic [AW-1:0]     chk_addr [NCHK];
  logic [NCHK-1:0]   win_ok;
  logic              win_bad;
  logic [DW-1:0]     word0;

  logic             g_zero, g_fmt12, g_over;
  logic [4:0]       g_bpp;
  logic [AW-1:0]    g_off;
  logic [DIM_W+1:0] g_stride;
  logic [DIM_W-1:0] g_first;
  logic [DIM_W:0]   g_lines;

  assign top_cur = idx ? buf1_top : buf0_top;
  assign bot_cur = idx ? buf1_bot : buf0_bot;
  assign cur_buf = idx;

  assign chk_addr[0] = buf0_top;
  assign chk_addr[1] = buf0_bot;
  assign chk_addr[2] = buf1_top;
  assign chk_addr[3] = buf1_bot;

  generate
    for (genvar g = 0; g < NCHK; g++) begin : g_win
      lcd_fs_win #(.AW(AW)) u_win (
        .addr (chk_addr[g]),
        .lo   (valid_lo),
        .hi   (valid_hi),
        .ok   (win_ok[g])
      );
    end
  endgenerate

  assign win_bad = !win_ok[0] || !win_ok[1] ||
                   (dual_en && (!win_ok[2] || !win_ok[3]));

  assign rd_req_valid = (st == ST_ISSUE);
  assign rd_req_addr  = top_cur + AW'({cnt, 1'b0});

  lcd_fs_pal #(.DW(DW), .PAL_N(PAL_N)) u_pal (
    .clk   (clk),
    .rst_n (rst_n),
    .we    ((st == ST_WAIT) && rd_rsp_valid),
    .waddr (cnt),
    .wdata (rd_rsp_data),
    .raddr (pal_rd_idx),
    .rdata (pal_rd_data),
    .word0 (word0)
  );

  lcd_fs_geom #(.AW(AW), .DIM_W(DIM_W), .DW(DW)) u_geom (
    .hdr       (word0),
    .tft       (tft_en),
    .lmode     (load_mode),
    .width_m1  (width_m1),
    .height_m1 (height_m1),
    .subpanel  (subpanel),
    .top       (top_cur),
    .bot       (bot_cur),
    .code_zero (g_zero),
    .bpp       (g_bpp),
    .fmt12     (g_fmt12),
    .offset    (g_off),
    .stride    (g_stride),
    .overrun   (g_over),
    .first     (g_first),
    .lines     (g_lines)
  );

  assign shut = ((st == ST_CHECK) && win_bad) ||
                ((st == ST_EVAL) && !g_zero && g_over);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      cnt         <= '0;
      idx         <= 1'b0;
      en_q        <= 1'b0;
      fresh       <= 1'b0;
      active      <= 1'b0;
      pix_base    <= '0;
      bpp         <= '0;
      fmt12       <= 1'b0;
      line_stride <= '0;
      first_line  <= '0;
      line_count  <= '0;
      setup_done  <= 1'b0;
      pal_loaded  <= 1'b0;
      depth_skip  <= 1'b0;
      sync_err    <= 1'b0;
      cond_evt    <= '0;
      dma_irq     <= 1'b0;
    end else begin
      setup_done <= 1'b0;
      pal_loaded <= 1'b0;
      depth_skip <= 1'b0;
      sync_err   <= 1'b0;
      cond_evt   <= '0;
      dma_irq    <= 1'b0;

      en_q <= ctl_en;
      if (ctl_en && !en_q) begin
        active <= 1'b1;
        fresh  <= 1'b1;
      end else if (!ctl_en) begin
        active <= 1'b0;
      end
      if (shut) active <= 1'b0;

      case (st)
        ST_IDLE: begin
          if (frame_start && active && (load_mode != MODE_NO_SETUP)) begin
            st <= ST_CHECK;
            if (fresh) begin
              idx   <= 1'b0;
              fresh <= 1'b0;
            end
          end
        end
        ST_CHECK: begin
          if (win_bad) begin
            cond_evt <= 3'b100;
            dma_irq  <= dma_ie[1];
            st       <= ST_IDLE;
          end else if (load_mode != MODE_DATA_ONLY) begin
            cnt <= '0;
            st  <= ST_ISSUE;
          end else begin
            st <= ST_EVAL;
          end
        end
        ST_ISSUE: begin
          if (rd_req_ready) st <= ST_WAIT;
        end
        ST_WAIT: begin
          if (rd_rsp_valid) begin
            if (cnt == PAL_AW'(PAL_N - 1)) begin
              pal_loaded <= 1'b1;
              st         <= ST_EVAL;
            end else begin
              cnt <= cnt + 1'b1;
              st  <= ST_ISSUE;
            end
          end
        end
        ST_EVAL: begin
          st <= ST_IDLE;
          if (g_zero) begin
            depth_skip <= 1'b1;
          end else if (g_over) begin
            sync_err <= 1'b1;
          end else begin
            pix_base    <= top_cur + g_off;
            bpp         <= g_bpp;
            fmt12       <= g_fmt12;
            line_stride <= g_stride;
            first_line  <= g_first;
            line_count  <= g_lines;
            setup_done  <= 1'b1;
            cond_evt    <= idx ? 3'b010 : 3'b001;
            dma_irq     <= dma_ie[0];
            if (dual_en) idx <= ~idx;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_frame_setup_chk.sv
module lcd_frame_setup_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [AW-1:0] rd_req_addr,
  input logic          setup_done,
  input logic          pal_loaded,
  input logic          depth_skip,
  input logic          sync_err,
  input logic [2:0]    cond_evt,
  input logic          dma_irq,
  input logic          active,
  input logic [4:0]    bpp
);
  // R5
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr)));

  // R6
  one_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({setup_done, depth_skip, sync_err, cond_evt[2]}));

  // R9
  sync_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !active);

  // R3
  win_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cond_evt[2] |=> !active);

  // R10
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_irq |-> (cond_evt != 3'b000));

  // R6
  bpp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    setup_done |-> (($countones(bpp) == 1) && (bpp >= 5'd2)));

  // R4
  pal_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_loaded |-> !rd_req_valid);
endmodule

bind lcd_frame_setup lcd_frame_setup_chk #(.AW(AW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_req_valid (rd_req_valid),
  .rd_req_ready (rd_req_ready),
  .rd_req_addr  (rd_req_addr),
  .setup_done   (setup_done),
  .pal_loaded   (pal_loaded),
  .depth_skip   (depth_skip),
  .sync_err     (sync_err),
  .cond_evt     (cond_evt),
  .dma_irq      (dma_irq),
  .active       (active),
  .bpp          (bpp)
);

// File: tb/lcd_frame_setup_tb.sv
module lcd_frame_setup_tb;
  localparam logic [31:0] B0T = 32'h0000_1000;
  localparam logic [31:0] B1T = 32'h0000_8000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n, ctl_en, frame_start, tft_en, dual_en;
  logic [1:0]  load_mode, dma_ie;
  logic [9:0]  width_m1, height_m1;
  logic [31:0] subpanel, buf0_top, buf0_bot, buf1_top, buf1_bot, valid_lo, valid_hi;
  logic        rd_req_valid, rd_req_ready, rd_rsp_valid;
  logic [31:0] rd_req_addr, pix_base;
  logic [15:0] rd_rsp_data, pal_rd_data;
  logic [7:0]  pal_rd_idx;
  logic        active, cur_buf, fmt12, setup_done, pal_loaded, depth_skip, sync_err, dma_irq;
  logic [4:0]  bpp;
  logic [11:0] line_stride;
  logic [9:0]  first_line;
  logic [10:0] line_count;
  logic [2:0]  cond_evt;

  lcd_frame_setup u_dut (.*);

  int errors = 0, checks = 0, cyc = 0, hs_cnt = 0;
  logic [15:0] hdr;
  logic [7:0]  lfsr;

  function automatic logic [15:0] memf(input logic [31:0] a, input logic [15:0] h);
    if (a == B0T || a == B1T) return h;
    return a[16:1] ^ 16'hA5C3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      rd_rsp_valid <= 1'b0; rd_req_ready <= 1'b0; lfsr <= 8'h5B; rd_rsp_data <= '0;
    end else begin
      lfsr         <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      rd_req_ready <= lfsr[0] | lfsr[2];
      rd_rsp_valid <= rd_req_valid && rd_req_ready;
      rd_rsp_data  <= memf(rd_req_addr, hdr);
      if (rd_req_valid && rd_req_ready) hs_cnt <= hs_cnt + 1;
    end
  end

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // outcome codes: 0 none, 1 done, 2 skip, 3 sync, 4 window
  int   o_kind, o_reqs;
  logic o_pal, o_irq, o_act_after;
  logic [2:0] o_cond;

  task automatic run_frame(input int limit);
    int h0;
    o_kind = 0; o_pal = 0; o_irq = 0; o_cond = 0;
    h0 = hs_cnt;
    @(negedge clk); frame_start = 1'b1;
    @(negedge clk); frame_start = 1'b0;
    for (int i = 0; i < limit && o_kind == 0; i++) begin
      @(negedge clk);
      if (pal_loaded) o_pal = 1;
      if (dma_irq) o_irq = 1;
      o_cond |= cond_evt;
      if (setup_done) o_kind = 1;
      else if (depth_skip) o_kind = 2;
      else if (sync_err) o_kind = 3;
      else if (cond_evt[2]) o_kind = 4;
    end
    @(negedge clk); o_act_after = active;
    o_reqs = hs_cnt - h0;
  endtask

  task automatic reenable();
    @(negedge clk); ctl_en = 1'b0;
    @(negedge clk); @(negedge clk); ctl_en = 1'b1;
    @(negedge clk); @(negedge clk);
  endtask

  typedef struct packed {
    logic [1:0]  lmode;
    logic [2:0]  code;
    logic        tft;
    logic [9:0]  wm1;
    logic [9:0]  hm1;
    logic [31:0] size;
    logic [31:0] sub;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{2'd0, 3'd1, 1'b0, 10'd15, 10'd7,  32'h1000, 32'h0},
    '{2'd0, 3'd2, 1'b0, 10'd31, 10'd3,  32'h1000, 32'h0},
    '{2'd0, 3'd3, 1'b0, 10'd7,  10'd7,  32'h1000, 32'h0},
    '{2'd0, 3'd4, 1'b0, 10'd9,  10'd9,  32'h1000, 32'h0},
    '{2'd0, 3'd7, 1'b1, 10'd9,  10'd9,  32'h1000, 32'h0},
    '{2'd0, 3'd5, 1'b1, 10'd15, 10'd15, 32'h03FE, 32'h0},
    '{2'd0, 3'd5, 1'b1, 10'd15, 10'd15, 32'h03FD, 32'h0},
    '{2'd0, 3'd0, 1'b0, 10'd3,  10'd3,  32'h1000, 32'h0},
    '{2'd0, 3'd2, 1'b0, 10'd7,  10'd7,  32'h1000, 32'hA005_0000},
    '{2'd2, 3'd6, 1'b0, 10'd19, 10'd9,  32'h1000, 32'h8003_0000},
    '{2'd3, 3'd6, 1'b0, 10'd3,  10'd3,  32'h1000, 32'h0}
  };

  initial begin
    int pcode, lg, eb, off, need, ekind;
    logic [31:0] eb_base;
    rst_n = 0; ctl_en = 0; frame_start = 0; load_mode = 0; tft_en = 0; dual_en = 0;
    dma_ie = 2'b01; width_m1 = 3; height_m1 = 3; subpanel = 0;
    buf0_top = B0T; buf0_bot = B0T + 32'h1000; buf1_top = B1T; buf1_bot = B1T + 32'h1000;
    valid_lo = 0; valid_hi = 32'hFFFF_FFFF; pal_rd_idx = 0; hdr = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1", "active", active, 0);
    chk("R1", "req_valid", rd_req_valid, 0);
    chk("R1", "events", {setup_done, pal_loaded, depth_skip, sync_err, cond_evt, dma_irq}, 0);
    chk("R1", "base/bpp/lines", {pix_base, bpp, line_count}, 0);

    // R2 disabled: frame start ignored
    run_frame(40);
    chk("R2", "disabled outcome", o_kind, 0);
    chk("R2", "disabled reads", o_reqs, 0);
    reenable();
    chk("R2", "active after enable", active, 1);
    load_mode = 2'd1;
    run_frame(40);
    chk("R2", "mode1 outcome", o_kind, 0);
    chk("R2", "mode1 reads", o_reqs, 0);

    pcode = 0;
    for (int v = 0; v < NV; v++) begin
      load_mode = VEC[v].lmode; tft_en = VEC[v].tft;
      width_m1 = VEC[v].wm1; height_m1 = VEC[v].hm1; subpanel = VEC[v].sub;
      buf0_bot = B0T + VEC[v].size;
      hdr = {1'b0, VEC[v].code, 12'h0AB};
      if (VEC[v].lmode != 2'd2) pcode = VEC[v].code;
      lg = (pcode == 1) ? 1 : (pcode == 2) ? 2 : (pcode == 3) ? 3 : 4;
      off = (VEC[v].lmode == 2'd2) ? 0 : (pcode >= 3) ? 32'h200 : 32'h20;
      need = off + (((VEC[v].wm1 + 1) * (VEC[v].hm1 + 1)) << lg) / 8;
      ekind = (pcode == 0) ? 2 : (need > VEC[v].size + 2) ? 3 : 1;
      run_frame(5000);
      chk("R6", $sformatf("row%0d outcome", v), o_kind, ekind);
      chk("R4", $sformatf("row%0d reads", v), o_reqs, (VEC[v].lmode == 2'd2) ? 0 : 256);
      chk("R4", $sformatf("row%0d pal_loaded", v), o_pal, VEC[v].lmode != 2'd2);
      if (ekind == 1) begin
        eb_base = B0T + off;
        chk("R6", $sformatf("row%0d bpp", v), bpp, 1 << lg);
        chk("R7", $sformatf("row%0d fmt12", v), fmt12, (lg == 4) && !VEC[v].tft);
        chk("R8", $sformatf("row%0d base", v), pix_base, eb_base);
        chk("R10", $sformatf("row%0d stride", v), line_stride, ((VEC[v].wm1 + 1) << lg) / 8);
        chk("R10", $sformatf("row%0d cond/irq", v), {o_cond, o_irq}, {3'b001, 1'b1});
        eb = (VEC[v].sub[31] && !VEC[v].sub[29]) ? VEC[v].sub[25:16] : VEC[v].hm1 + 1;
        chk("R12", $sformatf("row%0d lines", v), line_count, eb);
        chk("R12", $sformatf("row%0d first", v),
            first_line, (VEC[v].sub[31] && VEC[v].sub[29]) ? VEC[v].sub[25:16] : 0);
      end else if (ekind == 3) begin
        chk("R9", $sformatf("row%0d active after sync", v), o_act_after, 0);
        reenable();
      end else begin
        chk("R6", $sformatf("row%0d skip keeps active", v), o_act_after, 1);
      end
      if (v == 0) begin
        @(negedge clk); pal_rd_idx = 8'd5;
        @(negedge clk);
        chk("R4", "palette entry 5", pal_rd_data, memf(B0T + 32'd10, hdr));
        pal_rd_idx = 8'd0;
        @(negedge clk);
        chk("R4", "palette entry 0", pal_rd_data, hdr);
      end
    end

    // R3 window checks (data-only keeps palette code 6)
    load_mode = 2'd2; width_m1 = 3; height_m1 = 3; subpanel = 0;
    buf0_bot = B0T + 32'h1000; dma_ie = 2'b11;
    valid_hi = B0T + 32'h100;
    run_frame(100);
    chk("R3", "buf0 fault outcome", o_kind, 4);
    chk("R3", "buf0 fault irq", o_irq, 1);
    chk("R3", "buf0 fault active", o_act_after, 0);
    reenable();
    valid_hi = B1T + 32'h800; dual_en = 1; dma_ie = 2'b01;
    run_frame(100);
    chk("R3", "buf1 fault dual", o_kind, 4);
    chk("R3", "buf1 fault irq masked", o_irq, 0);
    reenable();
    dual_en = 0;
    run_frame(100);
    chk("R3", "buf1 ignored single", o_kind, 1);

    // R11 dual ping-pong and restart
    valid_hi = 32'hFFFF_FFFF; dual_en = 1;
    reenable();
    run_frame(100);
    chk("R11", "dual f0 cond", o_cond, 3'b001);
    chk("R11", "dual f0 base", pix_base, B0T);
    dma_ie = 2'b10;
    run_frame(100);
    chk("R11", "dual f1 cond", o_cond, 3'b010);
    chk("R11", "dual f1 base", pix_base, B1T);
    chk("R10", "irq off when bit0 clear", o_irq, 0);
    dma_ie = 2'b01;
    run_frame(100);
    chk("R11", "dual f2 cond", o_cond, 3'b001);
    reenable();
    run_frame(100);
    chk("R11", "restart uses buffer 0", o_cond, 3'b001);
    dual_en = 0;
    run_frame(100);
    chk("R11", "single stays", o_cond, 3'b010);
    run_frame(100);
    chk("R11", "single stays again", o_cond, 3'b010);

    summary();
    $finish;
  end
endmodule